// File: doc/BRIEF.md
# Four-Way Integer Dot-Product Accumulator

This block is a vector datapath that multiplies two source vectors element by element, sums the products in groups of four, and adds each group's sum to a wider accumulator lane taken from a third vector. It has two element sizes. Bytes can feed 32-bit accumulators, or 16-bit halfwords can feed 64-bit accumulators. Elements are read as signed or unsigned according to a select input.

Each valid/ready handshake processes one whole vector. The result is held in a register and offered on an output valid/ready pair in the cycle after the handshake. An operation size, given in bytes, sets how many low accumulator lanes are computed. Destination bytes above the computed lanes and below a maximum size are cleared. Bytes at or above the maximum size return the accumulator input unchanged.

Top module: `dot_accum_top`

## Requirements
- R1: In byte mode (`wideElem`=0), the 32-bit lane i (bits 32i+31..32i) equals the accumulator lane plus the sum of the four products of the bytes at byte positions 4i..4i+3 of `srcA` and `srcB`. The sum wraps modulo 2^32 and sets no flag.
- R2: In halfword mode (`wideElem`=1), the 64-bit lane j (bits 64j+63..64j) equals the accumulator lane plus the sum of the four products of the halfwords at halfword positions 4j..4j+3. The sum wraps modulo 2^64.
- R3: With `isSigned`=1, every element is sign-extended before it is multiplied. With `isSigned`=0, every element is zero-extended.
- R4: Only the lowest floor(`oprBytes` / lane bytes) lanes are computed, where the lane size is 4 bytes in byte mode and 8 bytes in halfword mode. A lane that is only partly covered by `oprBytes` is not computed.
- R5: Every byte that lies outside the computed lanes and below `maxBytes` is zero in the result.
- R6: Every byte that lies outside the computed lanes and at or above `maxBytes` equals the matching byte of `accIn`.
- R7: `inReady` is high whenever `outValid` is low or `outReady` is high. After a handshake, `outValid` and the new `result` appear on the next rising edge.
- R8: While `outValid` is high and `outReady` is low, `outValid` and `result` stay stable and new inputs are not accepted.
- R9: After reset, `outValid` is low and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands are presented |
| inReady | output | 1 | Block can accept operands this cycle |
| srcA | input | 8*VEC_BYTES | First source vector |
| srcB | input | 8*VEC_BYTES | Second source vector |
| accIn | input | 8*VEC_BYTES | Accumulator vector |
| isSigned | input | 1 | 1: signed elements, 0: unsigned elements |
| wideElem | input | 1 | 0: bytes into 32-bit lanes, 1: halfwords into 64-bit lanes |
| oprBytes | input | $clog2(VEC_BYTES)+1 | Operation size in bytes |
| maxBytes | input | $clog2(VEC_BYTES)+1 | Size in bytes up to which the tail is cleared |
| outValid | output | 1 | Result register holds an unread result |
| outReady | input | 1 | Consumer takes the result this cycle |
| result | output | 8*VEC_BYTES | Registered result vector |

## Verification
Two things can happen in the same cycle: the consumer draining the held result, and a new operand set being accepted into the result register. The bench provokes this by driving `inValid` and `outReady` from independent random draws while the output is occupied, so that drain-and-refill cycles mix with stalls and idle cycles. Every accepted operand set is pushed into an ordered scoreboard with a result computed by a bench model. Each drained result must match the head of that scoreboard, which shows that no result is lost, repeated or overwritten when the two events coincide.

// File: rtl/dot_pkg.sv
package dot_pkg;
  // strobes the control issues to the datapath
  typedef struct packed {
    logic capture;   // load the result register this edge
    logic drain;     // held result leaves this edge
  } dotStrobe_t;
endpackage

// File: rtl/dot_chunk.sv
// One 64-bit slice of the vector: two byte-mode lanes or one halfword-mode lane.
module dot_chunk #(
  parameter int IDX   = 0,
  parameter int CNT_W = 6
) (
  input  logic [63:0]      a,
  input  logic [63:0]      b,
  input  logic [63:0]      acc,
  input  logic             isSigned,
  input  logic             wideElem,
  input  logic [CNT_W-1:0] oprBytes,
  input  logic [CNT_W-1:0] maxBytes,
  output logic [63:0]      res
);
  localparam int BASE_BYTE = 8 * IDX;

  logic [31:0] narrowSum [2];
  logic [63:0] wideSum;
  logic signed [8:0]  byteA, byteB;
  logic signed [17:0] byteProd;
  logic signed [16:0] halfA, halfB;
  logic signed [33:0] halfProd;
  logic [63:0] mixed;

  always_comb begin
    byteA = '0; byteB = '0; byteProd = '0;
    for (int g = 0; g < 2; g++) begin
      narrowSum[g] = acc[32*g +: 32];
      for (int k = 0; k < 4; k++) begin
        byteA = {isSigned & a[8*(4*g+k)+7], a[8*(4*g+k) +: 8]};
        byteB = {isSigned & b[8*(4*g+k)+7], b[8*(4*g+k) +: 8]};
        byteProd = byteA * byteB;
        narrowSum[g] = narrowSum[g] + {{14{byteProd[17]}}, byteProd};
      end
    end
  end

  always_comb begin
    halfA = '0; halfB = '0; halfProd = '0;
    wideSum = acc;
    for (int k = 0; k < 4; k++) begin
      halfA = {isSigned & a[16*k+15], a[16*k +: 16]};
      halfB = {isSigned & b[16*k+15], b[16*k +: 16]};
      halfProd = halfA * halfB;
      wideSum = wideSum + {{30{halfProd[33]}}, halfProd};
    end
  end

  always_comb begin
    mixed = wideElem ? wideSum : {narrowSum[1], narrowSum[0]};
    for (int j = 0; j < 8; j++) begin
      logic laneOn;
      if (wideElem) laneOn = (int'(oprBytes) / 8) > IDX;
      else          laneOn = (int'(oprBytes) / 4) > (2 * IDX + j / 4);
      if (laneOn)                              res[8*j +: 8] = mixed[8*j +: 8];
      else if (int'(maxBytes) > BASE_BYTE + j) res[8*j +: 8] = 8'h00;
      else                                     res[8*j +: 8] = acc[8*j +: 8];
    end
  end
endmodule

// File: rtl/dot_datapath.sv
module dot_datapath
  import dot_pkg::*;
#(
  parameter int VEC_BYTES = 32,
  parameter int CNT_W     = $clog2(VEC_BYTES) + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dotStrobe_t             strobe,
  input  logic [8*VEC_BYTES-1:0] srcA,
  input  logic [8*VEC_BYTES-1:0] srcB,
  input  logic [8*VEC_BYTES-1:0] accIn,
  input  logic                   isSigned,
  input  logic                   wideElem,
  input  logic [CNT_W-1:0]       oprBytes,
  input  logic [CNT_W-1:0]       maxBytes,
  output logic [8*VEC_BYTES-1:0] result
);
  localparam int CHUNKS = VEC_BYTES / 8;

  logic [8*VEC_BYTES-1:0] nextResult;
  logic [8*VEC_BYTES-1:0] resultQ;

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    dot_chunk #(.IDX(c), .CNT_W(CNT_W)) u_chunk (
      .a(srcA[64*c +: 64]), .b(srcB[64*c +: 64]), .acc(accIn[64*c +: 64]),
      .isSigned(isSigned), .wideElem(wideElem),
      .oprBytes(oprBytes), .maxBytes(maxBytes),
      .res(nextResult[64*c +: 64])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)               resultQ <= '0;
    else if (strobe.capture) resultQ <= nextResult;
  end

  assign result = resultQ;

  // R1
  zero_product_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && !wideElem && srcB == '0 && int'(oprBytes) >= VEC_BYTES
    |=> resultQ == $past(accIn));

  // R5
  cleared_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && int'(oprBytes) < 4 && int'(maxBytes) >= VEC_BYTES
    |=> resultQ == '0);
endmodule

// File: rtl/dot_ctrl.sv
module dot_ctrl
  import dot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output dotStrobe_t strobe
);
  logic validQ;

  assign inReady        = !validQ || outReady;
  assign strobe.capture = inValid && inReady;
  assign strobe.drain   = validQ && outReady;

  always_ff @(posedge clk) begin
    if (!rstN)               validQ <= 1'b0;
    else if (strobe.capture) validQ <= 1'b1;
    else if (strobe.drain)   validQ <= 1'b0;
  end

  assign outValid = validQ;

  // R7
  cap_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  // R8
  stall_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);
endmodule

// File: rtl/dot_accum_top.sv
module dot_accum_top
  import dot_pkg::*;
#(
  parameter int VEC_BYTES = 32,
  localparam int CNT_W    = $clog2(VEC_BYTES) + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [8*VEC_BYTES-1:0] srcA,
  input  logic [8*VEC_BYTES-1:0] srcB,
  input  logic [8*VEC_BYTES-1:0] accIn,
  input  logic                   isSigned,
  input  logic                   wideElem,
  input  logic [CNT_W-1:0]       oprBytes,
  input  logic [CNT_W-1:0]       maxBytes,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [8*VEC_BYTES-1:0] result
);
  dotStrobe_t strobe;

  dot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .strobe(strobe)
  );

  dot_datapath #(.VEC_BYTES(VEC_BYTES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcA(srcA), .srcB(srcB), .accIn(accIn),
    .isSigned(isSigned), .wideElem(wideElem),
    .oprBytes(oprBytes), .maxBytes(maxBytes), .result(result)
  );

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(result));
endmodule

// File: tb/dot_accum_top_bench.sv
`timescale 1ns/100ps
module dot_accum_top_bench;
  localparam int VB = 32;
  localparam int W  = 8 * VB;
  localparam int CW = $clog2(VB) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, outReady = 1'b0;
  logic inReady, outValid;
  logic [W-1:0] srcA = '0, srcB = '0, accIn = '0, result;
  logic isSigned = 1'b0, wideElem = 1'b0;
  logic [CW-1:0] oprBytes = '0, maxBytes = '0;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] sb [$];

  always #2.5 clk = ~clk;

  dot_accum_top #(.VEC_BYTES(VB)) u_dot_accum_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .srcA(srcA), .srcB(srcB), .accIn(accIn), .isSigned(isSigned),
    .wideElem(wideElem), .oprBytes(oprBytes), .maxBytes(maxBytes),
    .outValid(outValid), .outReady(outReady), .result(result)
  );

  function automatic longint ext(logic [15:0] v, int bits, bit sg);
    if (bits == 8) return sg ? longint'($signed(v[7:0])) : longint'(v[7:0]);
    return sg ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
      logic [W-1:0] acc, bit sg, bit wd, int opr, int mx);
    logic [W-1:0] r;
    int laneB = wd ? 8 : 4;
    int lanes = opr / laneB;
    for (int p = 0; p < VB; p++)
      r[8*p +: 8] = (p < mx) ? 8'h00 : acc[8*p +: 8];
    for (int l = 0; l < lanes; l++) begin
      longint s;
      if (wd) begin
        s = longint'(acc[64*l +: 64]);
        for (int k = 0; k < 4; k++)
          s += ext(a[64*l+16*k +: 16], 16, sg) * ext(b[64*l+16*k +: 16], 16, sg);
        r[64*l +: 64] = s;
      end else begin
        s = longint'(acc[32*l +: 32]);
        for (int k = 0; k < 4; k++)
          s += ext({8'h0, a[32*l+8*k +: 8]}, 8, sg) * ext({8'h0, b[32*l+8*k +: 8]}, 8, sg);
        r[32*l +: 32] = s[31:0];
      end
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rndVec();
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [W-1:0] fill(logic [15:0] pat, bit wd);
    logic [W-1:0] v;
    for (int i = 0; i < VB / 2; i++) v[16*i +: 16] = wd ? pat : {pat[7:0], pat[7:0]};
    return v;
  endfunction

  // one operation, output consumed right away; checks latency and value
  task automatic directed(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] acc,
      bit sg, bit wd, int opr, int mx, string tag);
    logic [W-1:0] exp;
    @(negedge clk);
    srcA = a; srcB = b; accIn = acc; isSigned = sg; wideElem = wd;
    oprBytes = CW'(opr); maxBytes = CW'(mx); inValid = 1'b1; outReady = 1'b1;
    exp = model(a, b, acc, sg, wd, opr, mx);
    #1 chk(inReady == 1'b1, "R7 ready", {{(W-1){1'b0}}, inReady}, 1);
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b1, "R7 valid", {{(W-1){1'b0}}, outValid}, 1);
    chk(result == exp, tag, result, exp);
  endtask

  initial begin
    logic [W-1:0] held, exp;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R9 valid", {{(W-1){1'b0}}, outValid}, 0);
    chk(result == '0, "R9 result", result, '0);
    rstN = 1'b1;

    directed(fill(16'h0080, 0), fill(16'h0080, 0), '0, 1, 0, VB, VB, "R1 R3 signed bytes");
    directed(fill(16'h00ff, 0), fill(16'h00ff, 0), '0, 0, 0, VB, VB, "R1 R3 unsigned bytes");
    directed(fill(16'h0001, 0), fill(16'h0001, 0), fill(16'hffff, 1), 0, 0, VB, VB, "R1 wrap");
    directed(fill(16'h8000, 1), fill(16'h8000, 1), '0, 1, 1, VB, VB, "R2 R3 signed halves");
    directed(fill(16'hffff, 1), fill(16'h0003, 1), '1, 0, 1, VB, VB, "R2 wrap");
    directed(rndVec(), rndVec(), rndVec(), 1, 0, 6, VB, "R4 R5 partial byte lane");
    directed(rndVec(), rndVec(), rndVec(), 0, 1, 12, 20, "R4 R6 partial halfword lane");
    directed(rndVec(), rndVec(), rndVec(), 1, 0, 0, VB, "R5 empty op");
    directed(rndVec(), rndVec(), rndVec(), 1, 1, VB / 2, 3 * VB / 4, "R6 passthrough");

    // stall: result held, new operands refused
    @(negedge clk);
    srcA = rndVec(); srcB = rndVec(); accIn = rndVec(); isSigned = 1; wideElem = 0;
    oprBytes = CW'(VB); maxBytes = CW'(VB); inValid = 1'b1; outReady = 1'b0;
    held = model(srcA, srcB, accIn, 1, 0, VB, VB);
    @(negedge clk);
    srcA = rndVec(); accIn = rndVec();
    #1 chk(inReady == 1'b0, "R8 not ready", {{(W-1){1'b0}}, inReady}, 0);
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b1 && result == held, "R8 hold", result, held);
    outReady = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R8 drain", {{(W-1){1'b0}}, outValid}, 0);

    // random phase: drain and refill can fall in one cycle
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      inValid  = ($urandom % 4) != 0;
      outReady = ($urandom % 3) != 0;
      srcA = rndVec(); srcB = rndVec(); accIn = rndVec();
      isSigned = $urandom % 2; wideElem = $urandom % 2;
      oprBytes = CW'($urandom % (VB + 1)); maxBytes = CW'($urandom % (VB + 1));
      #1;
      chk(inReady == (!outValid || outReady), "R7 ready rule",
          {{(W-1){1'b0}}, inReady}, {{(W-1){1'b0}}, (!outValid || outReady)});
      if (outValid && outReady) begin
        exp = sb.pop_front();
        chk(result == exp, "R1 R2 R3 R4 R5 R6 random", result, exp);
      end
      if (inValid && inReady)
        sb.push_back(model(srcA, srcB, accIn, isSigned, wideElem,
                           int'(oprBytes), int'(maxBytes)));
    end
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b1;
    #1;
    if (outValid) begin
      exp = sb.pop_front();
      chk(result == exp, "R7 final", result, exp);
    end
    chk(sb.size() == 0, "R7 scoreboard empty", W'(sb.size()), '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule